// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block runs the entry sequence an 8-bit CPU core performs between instructions when it must leave the normal instruction flow. It handles three kinds of entry: reset, non-maskable interrupt (NMI) and maskable interrupt (IRQ). When an entry is taken, the block captures the core's program counter, status byte and stack pointer. It then pushes the return context onto the stack page and fetches a 16-bit vector. When the sequence ends, it hands back the new program counter, the new status and the new stack pointer.

The core raises `slot` in the cycle between two instructions, while the sequencer is idle. At that point the sequencer decides which entry to take:

- NMI wins over IRQ.
- An IRQ is honoured only when the interrupt-disable flag sampled before the last instruction is clear.
- A jammed core takes no interrupt at all.

The one-shot requests (NMI and the temporary IRQ) are used up by that decision, whether or not an entry follows. Level IRQ sources stay asserted until their owner releases them. A reset request, including the one implied by leaving hardware reset, needs no slot. It clears the jam.

Top module: `irq_entry_seq`

## Requirements
- R1: An interrupt entry writes exactly three bytes, in this order: PC high, PC low, then status. Each write goes to address 0x0100 + SP, and SP drops by one after each write. SP wraps within its 8 bits, so a write at SP=0x00 is followed by one at 0x01FF. The returned SP equals the captured SP minus 3, modulo 256.
- R2: The pushed status byte equals the captured status with bit 4 (break) cleared and bit 5 (unused) set.
- R3: The vector is read low byte first, then high byte. The addresses are 0xFFFA/0xFFFB for NMI, 0xFFFE/0xFFFF for IRQ and 0xFFFC/0xFFFD for reset. The returned PC is {high byte, low byte}.
- R4: When an NMI and an IRQ are both pending at a slot, the NMI entry is taken.
- R5: An IRQ is taken only when `iFlagPrev` is 0 at the slot. After an IRQ entry, the returned status is the captured status with bit 4 cleared and bit 2 (interrupt-disable) set. After an NMI entry, it is the captured status with only bit 4 cleared.
- R6: An interrupt entry keeps `busy` high for exactly 7 cycles. `done` pulses for one cycle right after the last of them, and the results on `pcOut`, `statusOut` and `spOut` are valid then.
- R7: After `jamSet`, no interrupt entry starts. No stack write happens while `jammedOut` is high, and an NMI requested while jammed is discarded.
- R8: A reset entry runs after hardware reset is released and after each `resetReq` pulse. It needs no slot, keeps `busy` high for 2 cycles and writes nothing. It returns status 0x04, leaves SP as captured and clears `jammedOut`.
- R9: The NMI request and the temporary IRQ request are cleared by the slot decision, whether or not an entry is taken. Asserted `irqLines` stay pending, so the next slot with `iFlagPrev`=0 enters again.
- R10: Any single set bit of `irqLines` requests an IRQ.
- R11: No interrupt entry starts without `slot` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; on release a reset entry follows |
| resetReq | input | 1 | Pulse requesting a reset entry |
| slot | input | 1 | Core is between instructions; entry decision point |
| nmiSet | input | 1 | Pulse that latches an NMI request |
| irqTempSet | input | 1 | Pulse that latches a one-shot IRQ request |
| irqLines | input | NUM_IRQ | Level IRQ sources, any bit requests |
| iFlagPrev | input | 1 | Interrupt-disable flag latched before the last instruction |
| jamSet | input | 1 | Pulse marking the core as jammed |
| pcIn | input | 16 | Current program counter |
| statusIn | input | 8 | Current status byte |
| spIn | input | 8 | Current stack pointer |
| memRdData | input | 8 | Read data, valid in the cycle of `memRe` |
| memAddr | output | 16 | Memory address for stack write or vector read |
| memWe | output | 1 | Stack write strobe |
| memRe | output | 1 | Vector read strobe |
| memWrData | output | 8 | Stack write data |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle pulse after the sequence ends |
| pcOut | output | 16 | New program counter |
| statusOut | output | 8 | New status byte |
| spOut | output | 8 | New stack pointer |
| jammedOut | output | 1 | Core is jammed |

## Verification
A wrong stack pointer or a wrong captured PC shows up within the same entry. It appears as a stack write at the wrong address or with the wrong byte, at most four cycles after the slot, and again in `spOut` at `done`. A wrong state sequence changes the `busy` length or the order of writes and reads, and is visible inside the 7-cycle window. A pending flag that fails to clear stays hidden until the next quiet slot. There it shows as an unexpected entry, which is why every random trial is followed by a slot with nothing pending.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  localparam int STATUS_W = 8;
  localparam int BIT_I = 2;
  localparam int BIT_B = 4;
  localparam int BIT_U = 5;
  localparam logic [STATUS_W-1:0] RESET_STATUS = 8'(1 << BIT_I);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT1,
    ST_WAIT2,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_PUSH_ST,
    ST_VEC_LO,
    ST_VEC_HI
  } seqState_t;

  typedef enum logic [1:0] {
    K_RESET,
    K_NMI,
    K_IRQ
  } entryKind_t;

  typedef struct packed {
    logic        capture;
    logic        isReset;
    logic        pushHi;
    logic        pushLo;
    logic        pushSt;
    logic        setI;
    logic        vecLo;
    logic        vecHi;
    logic [15:0] vecAddr;
  } entryStrobes_t;

endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int          NUM_IRQ = 4,
  parameter logic [15:0] VEC_NMI = 16'hFFFA,
  parameter logic [15:0] VEC_RST = 16'hFFFC,
  parameter logic [15:0] VEC_IRQ = 16'hFFFE
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               resetReq,
  input  logic               slot,
  input  logic               nmiSet,
  input  logic               irqTempSet,
  input  logic [NUM_IRQ-1:0] irqLines,
  input  logic               iFlagPrev,
  input  logic               jamSet,
  output entryStrobes_t      strobe,
  output logic               busy,
  output logic               done,
  output logic               jammed
);

  seqState_t  state, nextState;
  entryKind_t kind;
  logic rstPend, nmiPend, tempPend, jamR, doneR;
  logic irqAny, startRst, decide, takeNmi, takeIrq;

  assign irqAny   = |irqLines;
  assign startRst = (state == ST_IDLE) && rstPend;
  assign decide   = (state == ST_IDLE) && !rstPend && slot &&
                    (nmiPend || tempPend || irqAny);
  assign takeNmi  = decide && !jamR && nmiPend;
  assign takeIrq  = decide && !jamR && !nmiPend && !iFlagPrev &&
                    (tempPend || irqAny);

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (startRst)                nextState = ST_VEC_LO;
        else if (takeNmi || takeIrq) nextState = ST_WAIT1;
      end
      ST_WAIT1:   nextState = ST_WAIT2;
      ST_WAIT2:   nextState = ST_PUSH_HI;
      ST_PUSH_HI: nextState = ST_PUSH_LO;
      ST_PUSH_LO: nextState = ST_PUSH_ST;
      ST_PUSH_ST: nextState = ST_VEC_LO;
      ST_VEC_LO:  nextState = ST_VEC_HI;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    logic [15:0] base;
    case (kind)
      K_NMI:   base = VEC_NMI;
      K_IRQ:   base = VEC_IRQ;
      default: base = VEC_RST;
    endcase
    strobe.capture = startRst || takeNmi || takeIrq;
    strobe.isReset = startRst;
    strobe.pushHi  = (state == ST_PUSH_HI);
    strobe.pushLo  = (state == ST_PUSH_LO);
    strobe.pushSt  = (state == ST_PUSH_ST);
    strobe.setI    = (state == ST_PUSH_ST) && (kind == K_IRQ);
    strobe.vecLo   = (state == ST_VEC_LO);
    strobe.vecHi   = (state == ST_VEC_HI);
    strobe.vecAddr = base + {15'd0, (state == ST_VEC_HI)};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      kind     <= K_RESET;
      rstPend  <= 1'b1;
      nmiPend  <= 1'b0;
      tempPend <= 1'b0;
      jamR     <= 1'b0;
      doneR    <= 1'b0;
    end else begin
      state    <= nextState;
      doneR    <= (state == ST_VEC_HI);
      rstPend  <= (rstPend && !startRst) || resetReq;
      nmiPend  <= (nmiPend && !decide) || nmiSet;
      tempPend <= (tempPend && !decide) || irqTempSet;
      if (startRst)    jamR <= 1'b0;
      else if (jamSet) jamR <= 1'b1;
      if (startRst)     kind <= K_RESET;
      else if (takeNmi) kind <= K_NMI;
      else if (takeIrq) kind <= K_IRQ;
    end
  end

  assign busy   = (state != ST_IDLE);
  assign done   = doneR;
  assign jammed = jamR;

endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp
  import irq_entry_pkg::*;
#(
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input  logic          clk,
  input  logic          rstN,
  input  entryStrobes_t strobe,
  input  logic [15:0]   pcIn,
  input  logic [7:0]    statusIn,
  input  logic [7:0]    spIn,
  input  logic [7:0]    memRdData,
  output logic [15:0]   memAddr,
  output logic          memWe,
  output logic          memRe,
  output logic [7:0]    memWrData,
  output logic [15:0]   pcOut,
  output logic [7:0]    statusOut,
  output logic [7:0]    spOut
);

  localparam logic [7:0] MASK_B = 8'(1 << BIT_B);
  localparam logic [7:0] MASK_U = 8'(1 << BIT_U);
  localparam logic [7:0] MASK_I = 8'(1 << BIT_I);

  logic [15:0] pcR;
  logic [7:0]  stR, spR;
  logic        anyPush;

  assign anyPush = strobe.pushHi || strobe.pushLo || strobe.pushSt;
  assign memWe   = anyPush;
  assign memRe   = strobe.vecLo || strobe.vecHi;

  always_comb begin
    memAddr = 16'h0000;
    if (anyPush)    memAddr = {STACK_PAGE, spR};
    else if (memRe) memAddr = strobe.vecAddr;
  end

  always_comb begin
    memWrData = 8'h00;
    if (strobe.pushHi)      memWrData = pcR[15:8];
    else if (strobe.pushLo) memWrData = pcR[7:0];
    else if (strobe.pushSt) memWrData = stR | MASK_U;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcR <= 16'h0000;
      stR <= 8'h00;
      spR <= 8'h00;
    end else if (strobe.capture) begin
      pcR <= pcIn;
      spR <= spIn;
      stR <= strobe.isReset ? RESET_STATUS : (statusIn & ~MASK_B);
    end else begin
      if (anyPush)       spR <= spR - 8'd1;
      if (strobe.setI)   stR <= stR | MASK_I;
      if (strobe.vecLo)  pcR[7:0]  <= memRdData;
      if (strobe.vecHi)  pcR[15:8] <= memRdData;
    end
  end

  assign pcOut     = pcR;
  assign statusOut = stR;
  assign spOut     = spR;

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int          NUM_IRQ    = 4,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VEC_NMI    = 16'hFFFA,
  parameter logic [15:0] VEC_RST    = 16'hFFFC,
  parameter logic [15:0] VEC_IRQ    = 16'hFFFE
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               resetReq,
  input  logic               slot,
  input  logic               nmiSet,
  input  logic               irqTempSet,
  input  logic [NUM_IRQ-1:0] irqLines,
  input  logic               iFlagPrev,
  input  logic               jamSet,
  input  logic [15:0]        pcIn,
  input  logic [7:0]         statusIn,
  input  logic [7:0]         spIn,
  input  logic [7:0]         memRdData,
  output logic [15:0]        memAddr,
  output logic               memWe,
  output logic               memRe,
  output logic [7:0]         memWrData,
  output logic               busy,
  output logic               done,
  output logic [15:0]        pcOut,
  output logic [7:0]         statusOut,
  output logic [7:0]         spOut,
  output logic               jammedOut
);

  entryStrobes_t strobe;

  irq_entry_ctrl #(
    .NUM_IRQ(NUM_IRQ), .VEC_NMI(VEC_NMI), .VEC_RST(VEC_RST), .VEC_IRQ(VEC_IRQ)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .resetReq(resetReq), .slot(slot),
    .nmiSet(nmiSet), .irqTempSet(irqTempSet), .irqLines(irqLines),
    .iFlagPrev(iFlagPrev), .jamSet(jamSet), .strobe(strobe),
    .busy(busy), .done(done), .jammed(jammedOut)
  );

  irq_entry_dp #(.STACK_PAGE(STACK_PAGE)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pcIn(pcIn),
    .statusIn(statusIn), .spIn(spIn), .memRdData(memRdData),
    .memAddr(memAddr), .memWe(memWe), .memRe(memRe), .memWrData(memWrData),
    .pcOut(pcOut), .statusOut(statusOut), .spOut(spOut)
  );

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        done,
  input logic        memWe,
  input logic        memRe,
  input logic [15:0] memAddr,
  input logic [7:0]  spOut,
  input logic        jammedOut
);

  a_r1_write_in_page: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memAddr[15:8] == 8'h01);

  a_r1_sp_dec: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> spOut == $past(spOut) - 8'd1);

  a_r3_read_vector: assert property (@(posedge clk) disable iff (!rstN)
    memRe |-> (memAddr[15:3] == 13'h1FFF && memAddr[2:0] >= 3'd2));

  a_r3_no_rw_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  a_r7_jam_no_push: assert property (@(posedge clk) disable iff (!rstN)
    jammedOut |-> !memWe);

endmodule

bind irq_entry_seq irq_entry_chk uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .memWe(memWe),
  .memRe(memRe), .memAddr(memAddr), .spOut(spOut), .jammedOut(jammedOut)
);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
  localparam int NUM_IRQ = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, resetReq, slot, nmiSet, irqTempSet, iFlagPrev, jamSet;
  logic [NUM_IRQ-1:0] irqLines;
  logic [15:0] pcIn, memAddr, pcOut;
  logic [7:0] statusIn, spIn, memRdData, memWrData, statusOut, spOut;
  logic memWe, memRe, busy, done, jammedOut;
  logic [7:0] vecMem [0:7];

  assign memRdData = (memAddr[15:3] == 13'h1FFF) ? vecMem[memAddr[2:0]] : 8'h00;

  irq_entry_seq #(.NUM_IRQ(NUM_IRQ)) dut (
    .clk(clk), .rstN(rstN), .resetReq(resetReq), .slot(slot), .nmiSet(nmiSet),
    .irqTempSet(irqTempSet), .irqLines(irqLines), .iFlagPrev(iFlagPrev),
    .jamSet(jamSet), .pcIn(pcIn), .statusIn(statusIn), .spIn(spIn),
    .memRdData(memRdData), .memAddr(memAddr), .memWe(memWe), .memRe(memRe),
    .memWrData(memWrData), .busy(busy), .done(done), .pcOut(pcOut),
    .statusOut(statusOut), .spOut(spOut), .jammedOut(jammedOut)
  );

  int checks = 0, errors = 0;
  int busyCnt, nW, nR;
  bit doneSeen;
  logic [15:0] wAddr [0:3];
  logic [7:0]  wData [0:3];
  logic [15:0] rAddr [0:3];
  logic [15:0] dPc;
  logic [7:0]  dSt, dSp;
  logic        dJam;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic observe();
    busyCnt = 0; nW = 0; nR = 0; doneSeen = 0;
    for (int i = 0; i < 12; i++) begin
      if (busy) busyCnt++;
      if (memWe && nW < 4) begin wAddr[nW] = memAddr; wData[nW] = memWrData; nW++; end
      if (memRe && nR < 4) begin rAddr[nR] = memAddr; nR++; end
      if (done) begin
        doneSeen = 1; dPc = pcOut; dSt = statusOut; dSp = spOut; dJam = jammedOut;
      end
      @(negedge clk);
    end
  endtask

  task automatic fireSlot();
    slot = 1'b1;
    @(negedge clk);
    slot = 1'b0;
    observe();
  endtask

  task automatic randVec();
    for (int k = 0; k < 8; k++) vecMem[k] = 8'($urandom);
  endtask

  // kind: 0 none, 1 NMI, 2 IRQ
  function automatic int expKind(bit nmi, bit tmp, logic [NUM_IRQ-1:0] lines, bit iPrev);
    if (nmi) return 1;
    if (!iPrev && (tmp || lines != 0)) return 2;
    return 0;
  endfunction

  task automatic checkEntry(string req, int kind, logic [15:0] pc, logic [7:0] st, logic [7:0] sp);
    logic [15:0] base;
    logic [7:0] expSt;
    base  = (kind == 1) ? 16'hFFFA : 16'hFFFE;
    expSt = (kind == 1) ? (st & 8'hEF) : ((st & 8'hEF) | 8'h04);
    chk("R6", "busy cycles", busyCnt, 7);
    chk("R6", "done seen", doneSeen, 1);
    chk("R1", "write count", nW, 3);
    chk("R1", "push hi addr", wAddr[0], {8'h01, sp});
    chk("R1", "push lo addr", wAddr[1], {8'h01, 8'(sp - 8'd1)});
    chk("R1", "push st addr", wAddr[2], {8'h01, 8'(sp - 8'd2)});
    chk("R1", "push hi data", wData[0], pc[15:8]);
    chk("R1", "push lo data", wData[1], pc[7:0]);
    chk("R2", "pushed status", wData[2], (st & 8'hEF) | 8'h20);
    chk("R3", "read count", nR, 2);
    chk(req, "vector lo addr", rAddr[0], base);
    chk("R3", "vector hi addr", rAddr[1], base + 16'd1);
    chk("R3", "new pc", dPc, {vecMem[base[2:0] + 3'd1], vecMem[base[2:0]]});
    chk("R5", "new status", dSt, expSt);
    chk("R1", "new sp", dSp, 8'(sp - 8'd3));
  endtask

  task automatic runTrial(string req, logic [15:0] pc, logic [7:0] st, logic [7:0] sp,
                          bit iPrev, bit nmi, bit tmp, logic [NUM_IRQ-1:0] lines);
    int kind;
    randVec();
    pcIn = pc; statusIn = st; spIn = sp; iFlagPrev = iPrev;
    nmiSet = nmi; irqTempSet = tmp; irqLines = lines;
    @(negedge clk);
    nmiSet = 1'b0; irqTempSet = 1'b0;
    fireSlot();
    kind = expKind(nmi, tmp, lines, iPrev);
    if (kind != 0) checkEntry(req, kind, pc, st, sp);
    else chk("R5", "no entry when masked", busyCnt, 0);
    irqLines = '0;
    fireSlot();
    chk("R9", "one-shot requests cleared", busyCnt, 0);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 0; resetReq = 0; slot = 0; nmiSet = 0; irqTempSet = 0;
    iFlagPrev = 0; jamSet = 0; irqLines = '0;
    pcIn = 16'h1234; statusIn = 8'hFF; spIn = 8'hFD;
    randVec();
    repeat (3) @(negedge clk);
    chk("R8", "busy in reset", busy, 0);
    chk("R8", "done in reset", done, 0);
    chk("R8", "jam in reset", jammedOut, 0);
    rstN = 1;
    observe();
    chk("R8", "reset busy cycles", busyCnt, 2);
    chk("R8", "reset writes", nW, 0);
    chk("R3", "reset vector lo", rAddr[0], 16'hFFFC);
    chk("R3", "reset vector hi", rAddr[1], 16'hFFFD);
    chk("R3", "reset pc", dPc, {vecMem[5], vecMem[4]});
    chk("R8", "reset status", dSt, 8'h04);
    chk("R8", "reset sp", dSp, 8'hFD);

    // R11: NMI latched but no slot
    randVec();
    pcIn = 16'hABCD; statusIn = 8'h13; spIn = 8'h80;
    nmiSet = 1; @(negedge clk); nmiSet = 0;
    observe();
    chk("R11", "no entry without slot", busyCnt, 0);
    fireSlot();
    checkEntry("R3", 1, 16'hABCD, 8'h13, 8'h80);

    // R4: NMI over IRQ
    runTrial("R4", 16'h4000, 8'h30, 8'hF0, 1'b0, 1'b1, 1'b1, 4'b0011);
    // R10: each single line requests
    for (int b = 0; b < NUM_IRQ; b++)
      runTrial("R10", 16'(16'h2000 + b), 8'h41, 8'hE0, 1'b0, 1'b0, 1'b0, 4'(1 << b));
    // R1: stack wrap
    runTrial("R1", 16'h8001, 8'hC3, 8'h01, 1'b0, 1'b1, 1'b0, 4'b0000);
    // R5 / R9: masked one-shot IRQ discarded
    runTrial("R5", 16'h5555, 8'h00, 8'h40, 1'b1, 1'b0, 1'b1, 4'b0000);

    // R9: level line stays pending, entered again
    randVec();
    pcIn = 16'h6000; statusIn = 8'h01; spIn = 8'h90; iFlagPrev = 0;
    irqLines = 4'b0100;
    fireSlot();
    chk("R9", "level irq first entry", busyCnt, 7);
    fireSlot();
    chk("R9", "level irq entered again", busyCnt, 7);
    chk("R3", "level irq vector", rAddr[0], 16'hFFFE);
    irqLines = '0;

    // R7: jammed core ignores NMI, reset clears jam
    jamSet = 1; @(negedge clk); jamSet = 0;
    chk("R7", "jam flag set", jammedOut, 1);
    nmiSet = 1; @(negedge clk); nmiSet = 0;
    fireSlot();
    chk("R7", "no entry while jammed", busyCnt, 0);
    chk("R7", "no writes while jammed", nW, 0);
    chk("R7", "still jammed", jammedOut, 1);
    resetReq = 1; @(negedge clk); resetReq = 0;
    observe();
    chk("R8", "reset entry busy", busyCnt, 2);
    chk("R8", "jam cleared by reset", dJam, 0);
    chk("R8", "status after reset", dSt, 8'h04);
    fireSlot();
    chk("R7", "nmi dropped while jammed", busyCnt, 0);

    // random mix
    for (int t = 0; t < 60; t++) begin
      logic [NUM_IRQ-1:0] ln;
      ln = ($urandom % 3 == 0) ? NUM_IRQ'($urandom) : '0;
      runTrial("R3", 16'($urandom), 8'($urandom), 8'($urandom), 1'($urandom),
               ($urandom % 3 == 0), 1'($urandom), ln);
    end

    finishRun();
  end
endmodule